// File: doc/BRIEF.md
# Set-Associative Cache Tag Model

This block models only the tag side of a set-associative cache. A stream of memory accesses arrives one at a time. Each access is marked as a hit, a miss, or a miss that forces out a resident line. Three running totals are kept for those outcomes. No data is stored. The block holds, for every line, a valid flag, the stored tag and a recency stamp. The stamp is copied from a sequence counter that advances once for each accepted access that performs a lookup. A smaller stamp therefore marks a line that was used longer ago. When a set is full, the line with the smallest stamp is replaced.

Requests use a valid/ready handshake and carry a two-bit operation code and an address. Loads and stores perform one lookup each. A modify performs two back-to-back lookups under the same stamp. The block drops ready for one cycle while the second lookup runs. Instruction fetches are accepted but leave the block unchanged. The number of set-index bits, the ways per set, the block-offset bits and the widths are build-time parameters. Zero set-index bits gives a fully associative cache and one way gives a direct-mapped one.

Top module: `cache_tag_model`

## Requirements
- R1: The address is split into a block offset (the low OFF_BITS bits), a set index (the next SET_BITS bits) and a tag (all remaining upper bits). The offset has no influence on the outcome, so two addresses that differ only in offset bits address the same line.
- R2: A lookup hits when the selected set holds a valid line whose tag equals the request tag. One cycle after the lookup, `res_hit` pulses for one cycle and `hit_count` rises by one. The line's stamp is refreshed so that it becomes the most recently used line.
- R3: A miss in a set that still has an invalid line fills the lowest-indexed invalid line with the new tag and the current stamp. `res_miss` pulses, `miss_count` rises by one, and neither `res_evict` nor `evict_count` changes.
- R4: A miss in a set whose lines are all valid replaces the line with the smallest stamp, taking the lowest index on a tie. `res_miss` and `res_evict` pulse together, and `miss_count` and `evict_count` each rise by one.
- R5: `req_op` encodes 2'b00 as instruction fetch, 2'b01 as load, 2'b10 as store and 2'b11 as modify. A load or a store performs exactly one lookup, with its result one cycle after acceptance.
- R6: A modify performs two lookups in consecutive cycles with the same stamp, so the second one always hits. `req_ready` is low in the cycle after a modify is accepted, and a request held during that cycle is accepted only once ready returns.
- R7: An instruction fetch is accepted but produces no result pulse, changes no counter and does not advance the stamp sequence.
- R8: While `rst` is high, at the clock edge all lines become invalid and all stamps, the sequence counter and the three counters are cleared. After reset the pulses are low, ready is high and the first access to any set misses.
- R9: Each counter is CNT_W bits wide, wraps rather than saturates, and changes only in the cycle its result pulse is high, by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Active-high synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_op | input | 2 | Operation: 00 fetch, 01 load, 10 store, 11 modify |
| req_addr | input | ADDR_W | Access address |
| res_hit | output | 1 | One-cycle pulse: lookup hit |
| res_miss | output | 1 | One-cycle pulse: lookup missed |
| res_evict | output | 1 | One-cycle pulse with res_miss: a valid line was replaced |
| hit_count | output | CNT_W | Running hit total |
| miss_count | output | CNT_W | Running miss total |
| evict_count | output | CNT_W | Running eviction total |

## Verification
The bench builds three copies side by side and drives the same request stream into all of them:
- **Default copy:** four sets of two ways.
- **Direct-mapped copy:** eight sets of one way.
- **Fully associative copy:** a single set of four ways.

The one-way copy turns every conflict into an immediate eviction with no victim choice. The single-set copy reaches the zero-width set-index variant and makes stamp ordering decide among four candidates. The two-way copy exercises free-line filling and oldest-line selection within small sets, which directed address sequences aim at. A behavioural reference covering all three shapes predicts each pulse and count for directed and pseudo-random traces.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
   typedef enum logic [1:0] {
      OP_FETCH  = 2'b00,
      OP_LOAD   = 2'b01,
      OP_STORE  = 2'b10,
      OP_MODIFY = 2'b11
   } access_op_e;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
   parameter int ADDR_W   = 32,
   parameter int SET_BITS = 2,
   parameter int OFF_BITS = 4,
   localparam int SET_IDX_W = (SET_BITS > 0) ? SET_BITS : 1,
   localparam int TAG_W     = ADDR_W - SET_BITS - OFF_BITS
) (
   input  logic [ADDR_W-1:0]    addr_i,
   output logic [SET_IDX_W-1:0] set_o,
   output logic [TAG_W-1:0]     tag_o
);
   assign tag_o = addr_i[ADDR_W-1 -: TAG_W];

   generate
      if (SET_BITS == 0) begin : g_one_set
         assign set_o = '0;
      end else begin : g_many_sets
         assign set_o = addr_i[OFF_BITS +: SET_BITS];
      end

      // Offset bits never take part in the lookup.
      if (OFF_BITS > 0) begin : g_off
         logic unused_offset;
         assign unused_offset = ^addr_i[OFF_BITS-1:0];
      end
   endgenerate
endmodule

// File: rtl/cache_way_pick.sv
module cache_way_pick #(
   parameter int WAYS    = 2,
   parameter int TAG_W   = 26,
   parameter int STAMP_W = 32,
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]              valid_i,
   input  logic [WAYS-1:0][TAG_W-1:0]   tags_i,
   input  logic [WAYS-1:0][STAMP_W-1:0] stamps_i,
   input  logic [TAG_W-1:0]             tag_i,
   output logic                         hit_o,
   output logic [WAY_W-1:0]             hit_way_o,
   output logic                         free_o,
   output logic [WAY_W-1:0]             free_way_o,
   output logic [WAY_W-1:0]             victim_way_o
);
   logic [STAMP_W-1:0] oldest;

   // Reverse scans: the last assignment is the lowest matching index.
   always_comb begin
      hit_o      = 1'b0;
      hit_way_o  = '0;
      free_o     = 1'b0;
      free_way_o = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (valid_i[w] && (tags_i[w] == tag_i)) begin
            hit_o     = 1'b1;
            hit_way_o = WAY_W'(w);
         end
         if (!valid_i[w]) begin
            free_o     = 1'b1;
            free_way_o = WAY_W'(w);
         end
      end
   end

   // Strict less-than keeps the lowest index among equal stamps.
   always_comb begin
      oldest       = stamps_i[0];
      victim_way_o = '0;
      for (int w = 1; w < WAYS; w++) begin
         if (stamps_i[w] < oldest) begin
            oldest       = stamps_i[w];
            victim_way_o = WAY_W'(w);
         end
      end
   end
endmodule

// File: rtl/cache_tag_model.sv
module cache_tag_model #(
   parameter int ADDR_W   = 32,
   parameter int SET_BITS = 2,
   parameter int WAYS     = 2,
   parameter int OFF_BITS = 4,
   parameter int STAMP_W  = 32,
   parameter int CNT_W    = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              res_hit,
   output logic              res_miss,
   output logic              res_evict,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count,
   output logic [CNT_W-1:0]  evict_count
);
   import cache_tag_pkg::*;

   localparam int SET_IDX_W = (SET_BITS > 0) ? SET_BITS : 1;
   localparam int SET_SLOTS = 1 << SET_IDX_W;
   localparam int TAG_W     = ADDR_W - SET_BITS - OFF_BITS;
   localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1;

   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("cache_tag_model: address too narrow for set and offset bits");
      end
      if (WAYS < 1) begin : g_bad_ways
         $error("cache_tag_model: WAYS must be at least 1");
      end
      if (STAMP_W < 2 || CNT_W < 1) begin : g_bad_width
         $error("cache_tag_model: stamp or counter width too small");
      end
   endgenerate

   // Line state
   logic [WAYS-1:0]              valid_q [SET_SLOTS];
   logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SET_SLOTS];
   logic [WAYS-1:0][STAMP_W-1:0] stamp_q [SET_SLOTS];

   logic [STAMP_W-1:0]   seq_q;
   logic                 pend_q;
   logic [SET_IDX_W-1:0] pend_set_q;
   logic [TAG_W-1:0]     pend_tag_q;
   logic [STAMP_W-1:0]   pend_stamp_q;

   logic             hit_q, miss_q, evict_q;
   logic [CNT_W-1:0] hit_cnt_q, miss_cnt_q, evict_cnt_q;

   access_op_e           op;
   logic [SET_IDX_W-1:0] live_set, lk_set;
   logic [TAG_W-1:0]     live_tag, lk_tag;
   logic [STAMP_W-1:0]   lk_stamp;
   logic                 accept, lk_go;
   logic                 pick_hit, pick_free;
   logic [WAY_W-1:0]     hit_way, free_way, victim_way, fill_way;

   assign op        = access_op_e'(req_op);
   assign req_ready = ~pend_q;
   assign accept    = req_valid & ~pend_q;
   assign lk_go     = pend_q | (accept & (op != OP_FETCH));
   assign lk_set    = pend_q ? pend_set_q   : live_set;
   assign lk_tag    = pend_q ? pend_tag_q   : live_tag;
   assign lk_stamp  = pend_q ? pend_stamp_q : seq_q;

   cache_addr_split #(
      .ADDR_W   (ADDR_W),
      .SET_BITS (SET_BITS),
      .OFF_BITS (OFF_BITS)
   ) u_split (
      .addr_i (req_addr),
      .set_o  (live_set),
      .tag_o  (live_tag)
   );

   cache_way_pick #(
      .WAYS    (WAYS),
      .TAG_W   (TAG_W),
      .STAMP_W (STAMP_W)
   ) u_pick (
      .valid_i      (valid_q[lk_set]),
      .tags_i       (tag_q[lk_set]),
      .stamps_i     (stamp_q[lk_set]),
      .tag_i        (lk_tag),
      .hit_o        (pick_hit),
      .hit_way_o    (hit_way),
      .free_o       (pick_free),
      .free_way_o   (free_way),
      .victim_way_o (victim_way)
   );

   always_comb begin
      if (pick_hit)       fill_way = hit_way;
      else if (pick_free) fill_way = free_way;
      else                fill_way = victim_way;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SET_SLOTS; s++) begin
            valid_q[s] <= '0;
            tag_q[s]   <= '0;
            stamp_q[s] <= '0;
         end
         seq_q        <= '0;
         pend_q       <= 1'b0;
         pend_set_q   <= '0;
         pend_tag_q   <= '0;
         pend_stamp_q <= '0;
         hit_q        <= 1'b0;
         miss_q       <= 1'b0;
         evict_q      <= 1'b0;
         hit_cnt_q    <= '0;
         miss_cnt_q   <= '0;
         evict_cnt_q  <= '0;
      end else begin
         hit_q   <= lk_go & pick_hit;
         miss_q  <= lk_go & ~pick_hit;
         evict_q <= lk_go & ~pick_hit & ~pick_free;
         if (lk_go) begin
            if (pick_hit) hit_cnt_q <= hit_cnt_q + 1'b1;
            else          miss_cnt_q <= miss_cnt_q + 1'b1;
            if (!pick_hit && !pick_free) evict_cnt_q <= evict_cnt_q + 1'b1;
            for (int w = 0; w < WAYS; w++) begin
               if (fill_way == WAY_W'(w)) begin
                  valid_q[lk_set][w] <= 1'b1;
                  tag_q[lk_set][w]   <= lk_tag;
                  stamp_q[lk_set][w] <= lk_stamp;
               end
            end
         end
         if (accept && op != OP_FETCH) seq_q <= seq_q + 1'b1;
         pend_q <= accept & (op == OP_MODIFY);
         if (accept && op == OP_MODIFY) begin
            pend_set_q   <= live_set;
            pend_tag_q   <= live_tag;
            pend_stamp_q <= seq_q;
         end
      end
   end

   assign res_hit     = hit_q;
   assign res_miss    = miss_q;
   assign res_evict   = evict_q;
   assign hit_count   = hit_cnt_q;
   assign miss_count  = miss_cnt_q;
   assign evict_count = evict_cnt_q;
endmodule

// File: rtl/cache_tag_model_chk.sv
module cache_tag_model_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic             req_ready,
   input logic [1:0]       req_op,
   input logic             res_hit,
   input logic             res_miss,
   input logic             res_evict,
   input logic [CNT_W-1:0] hit_count,
   input logic [CNT_W-1:0] miss_count,
   input logic [CNT_W-1:0] evict_count
);
   p_evict_needs_miss_r4: assert property (@(posedge clk) disable iff (rst)
      res_evict |-> res_miss);

   p_hit_excludes_miss_r2: assert property (@(posedge clk) disable iff (rst)
      res_hit |-> !res_miss);

   p_fetch_silent_r7: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && req_op == 2'b00) |=> (!res_hit && !res_miss));

   p_modify_second_hits_r6: assert property (@(posedge clk) disable iff (rst)
      !req_ready |=> (res_hit && req_ready));

   p_ready_drop_cause_r6: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && req_op != 2'b11) |=> req_ready);

   p_hit_count_step_r9: assert property (@(posedge clk) disable iff (rst)
      res_hit |-> (hit_count == $past(hit_count) + 1'b1));

   p_hit_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !res_hit |-> $stable(hit_count));

   p_miss_count_step_r9: assert property (@(posedge clk) disable iff (rst)
      res_miss |-> (miss_count == $past(miss_count) + 1'b1));

   p_evict_count_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !res_evict |-> $stable(evict_count));
endmodule

bind cache_tag_model cache_tag_model_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_op      (req_op),
   .res_hit     (res_hit),
   .res_miss    (res_miss),
   .res_evict   (res_evict),
   .hit_count   (hit_count),
   .miss_count  (miss_count),
   .evict_count (evict_count)
);

// File: tb/cache_tag_model_tb.sv
module cache_tag_model_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCFG = 3;
   localparam int OFFB = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = 2'b00;
   logic [31:0] req_addr = '0;

   logic        rd [NCFG];
   logic [2:0]  pl [NCFG];
   logic [31:0] hc [NCFG];
   logic [31:0] mc [NCFG];
   logic [31:0] ec [NCFG];

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cache_tag_model #(.SET_BITS(2), .WAYS(2), .OFF_BITS(OFFB)) u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rd[0]),
      .req_op(req_op), .req_addr(req_addr),
      .res_hit(pl[0][2]), .res_miss(pl[0][1]), .res_evict(pl[0][0]),
      .hit_count(hc[0]), .miss_count(mc[0]), .evict_count(ec[0]));

   cache_tag_model #(.SET_BITS(3), .WAYS(1), .OFF_BITS(OFFB)) u_dm (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rd[1]),
      .req_op(req_op), .req_addr(req_addr),
      .res_hit(pl[1][2]), .res_miss(pl[1][1]), .res_evict(pl[1][0]),
      .hit_count(hc[1]), .miss_count(mc[1]), .evict_count(ec[1]));

   cache_tag_model #(.SET_BITS(0), .WAYS(4), .OFF_BITS(OFFB)) u_fa (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rd[2]),
      .req_op(req_op), .req_addr(req_addr),
      .res_hit(pl[2][2]), .res_miss(pl[2][1]), .res_evict(pl[2][0]),
      .hit_count(hc[2]), .miss_count(mc[2]), .evict_count(ec[2]));

   // Reference model
   int          cfg_sb [NCFG] = '{2, 3, 0};
   int          cfg_w  [NCFG] = '{2, 1, 4};
   bit          mv [NCFG][8][4];
   int unsigned mt [NCFG][8][4];
   int unsigned ms [NCFG][8][4];
   int unsigned mseq;
   int unsigned eh [NCFG];
   int unsigned em [NCFG];
   int unsigned ee [NCFG];

   function automatic void ref_reset();
      for (int c = 0; c < NCFG; c++) begin
         eh[c] = 0; em[c] = 0; ee[c] = 0;
         for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++) begin
               mv[c][s][w] = 1'b0; mt[c][s][w] = 0; ms[c][s][w] = 0;
            end
      end
      mseq = 0;
   endfunction

   // Returns the expected pulse pattern {hit, miss, evict}.
   function automatic logic [2:0] ref_lookup(int c, logic [31:0] a, int unsigned st);
      int unsigned tg, st_set;
      int vic;
      tg     = a >> (OFFB + cfg_sb[c]);
      st_set = (a >> OFFB) & ((1 << cfg_sb[c]) - 1);
      for (int w = 0; w < cfg_w[c]; w++)
         if (mv[c][st_set][w] && mt[c][st_set][w] == tg) begin
            ms[c][st_set][w] = st; eh[c]++;
            return 3'b100;
         end
      em[c]++;
      for (int w = 0; w < cfg_w[c]; w++)
         if (!mv[c][st_set][w]) begin
            mv[c][st_set][w] = 1'b1; mt[c][st_set][w] = tg; ms[c][st_set][w] = st;
            return 3'b010;
         end
      vic = 0;
      for (int w = 1; w < cfg_w[c]; w++)
         if (ms[c][st_set][w] < ms[c][st_set][vic]) vic = w;
      mt[c][st_set][vic] = tg; ms[c][st_set][vic] = st; ee[c]++;
      return 3'b011;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input logic [2:0] e [NCFG], input string req);
      for (int c = 0; c < NCFG; c++) begin
         check(pl[c] === e[c], req, $sformatf("cfg%0d pulses", c), pl[c], e[c]);
         check({hc[c], mc[c], ec[c]} === {eh[c], em[c], ee[c]}, req,
               $sformatf("cfg%0d counters", c), {hc[c], mc[c], ec[c]},
               {eh[c], em[c], ee[c]});
      end
   endtask

   // One access; outputs are sampled at the falling edges after each lookup.
   task automatic send(input logic [1:0] op, input logic [31:0] a, input string req);
      logic [2:0] e [NCFG];
      int unsigned st;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a;
      st = mseq;
      if (op != 2'b00) mseq++;
      @(negedge clk);
      req_valid = 1'b0;
      for (int c = 0; c < NCFG; c++)
         e[c] = (op == 2'b00) ? 3'b000 : ref_lookup(c, a, st);
      check_all(e, req);
      if (op == 2'b11) begin
         check(rd[0] == 1'b0, "R6", "ready low during second lookup", rd[0], 0);
         @(negedge clk);
         for (int c = 0; c < NCFG; c++) e[c] = ref_lookup(c, a, st);
         check_all(e, "R6");
         check(rd[0] == 1'b1, "R6", "ready back", rd[0], 1);
      end
   endtask

   task automatic t_reset();
      for (int c = 0; c < NCFG; c++) begin
         check(pl[c] == 3'b000, "R8", "pulses after reset", pl[c], 0);
         check({hc[c], mc[c], ec[c]} == '0, "R8", "counters after reset",
               {hc[c], mc[c], ec[c]}, 0);
         check(rd[c] == 1'b1, "R8", "ready after reset", rd[c], 1);
      end
   endtask

   task automatic t_fill();
      send(2'b01, 32'h0000_0040, "R3");
      check(pl[0] == 3'b010, "R3", "first fill set0", pl[0], 3'b010);
      send(2'b01, 32'h0000_0080, "R3");
      check(pl[0] == 3'b010, "R3", "second fill set0 no evict", pl[0], 3'b010);
   endtask

   task automatic t_offset();
      send(2'b01, 32'h0000_004C, "R1");
      check(pl[0] == 3'b100, "R1", "other offset same block hits", pl[0], 3'b100);
      send(2'b10, 32'h0000_0087, "R2");
      check(pl[0] == 3'b100, "R2", "store hit", pl[0], 3'b100);
   endtask

   task automatic t_lru();
      send(2'b01, 32'h0000_0040, "R2");           // refresh tag 1
      send(2'b01, 32'h0000_00C0, "R4");           // evicts tag 2
      check(pl[0] == 3'b011, "R4", "full set evicts", pl[0], 3'b011);
      send(2'b01, 32'h0000_0040, "R4");
      check(pl[0] == 3'b100, "R4", "recent line kept", pl[0], 3'b100);
      send(2'b01, 32'h0000_0080, "R4");
      check(pl[0] == 3'b011, "R4", "oldest line was replaced", pl[0], 3'b011);
   endtask

   task automatic t_store_modify();
      send(2'b10, 32'h0000_0010, "R5");
      check(pl[0] == 3'b010, "R5", "store into empty set1", pl[0], 3'b010);
      send(2'b11, 32'h0000_0210, "R6");
   endtask

   task automatic t_modify_held();
      logic [2:0] e [NCFG];
      int unsigned st;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b11; req_addr = 32'h0000_0320;
      st = mseq; mseq++;
      @(negedge clk);
      req_op = 2'b01; req_addr = 32'h0000_0420;    // held while ready low
      for (int c = 0; c < NCFG; c++) e[c] = ref_lookup(c, 32'h0000_0320, st);
      check_all(e, "R6");
      check(rd[0] == 1'b0, "R6", "ready low with held request", rd[0], 0);
      @(negedge clk);
      for (int c = 0; c < NCFG; c++) e[c] = ref_lookup(c, 32'h0000_0320, st);
      check_all(e, "R6");
      st = mseq; mseq++;
      @(negedge clk);
      req_valid = 1'b0;
      for (int c = 0; c < NCFG; c++) e[c] = ref_lookup(c, 32'h0000_0420, st);
      check_all(e, "R6");
   endtask

   task automatic t_fetch();
      send(2'b00, 32'h0000_0999, "R7");
      send(2'b00, 32'h0000_0040, "R7");
      check(pl[0] == 3'b000, "R7", "fetch silent", pl[0], 0);
      send(2'b01, 32'h0000_0040, "R7");           // fetch did not change state
   endtask

   task automatic t_random();
      for (int i = 0; i < 400; i++)
         send(2'($urandom % 4), $urandom % 512, "R9");
   endtask

   initial begin
      ref_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_fill();
      t_offset();
      t_lru();
      t_store_modify();
      t_modify_held();
      t_fetch();
      t_random();
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule